// File: doc/BRIEF.md
# Mailbox Command Submission Sequencer

This block sits on the host side of a device mailbox. It runs one command at a time through the mailbox. A local client hands it an opcode and an input length, then streams the input bytes. The sequencer works the mailbox registers over a simple single-cycle read/write bus. It checks that the mailbox is idle, loads the command word and the payload window, and rings the doorbell. It then polls the doorbell until the device clears it or a deadline passes.

When the device finishes, the sequencer fetches the return code. Only when that code is zero does it read the output length back from the command register and stream the output bytes to the client. Every request ends with a one-cycle completion pulse. The pulse carries a result class, the return code and the number of bytes delivered.

The register layout the block relies on is fixed:
- Offset 0x04 is the control register. Its bit 0 is the doorbell, and a one there means busy.
- Offset 0x08 is the command register. It holds the opcode in bits 15:0 and the payload length in bits 36:16.
- Offset 0x10 is the status register. It holds the return code in bits 47:32.
- The payload window starts at offset 0x20, and word k of the window lies at 0x20 + 8k.

Bus reads return data in the same cycle. The polling deadline is `CLK_HZ / 1e6 * TIMEOUT_US` cycles, which gives 2 ms at the default clock. The input length must not exceed `PAYLOAD_BYTES`.

Top module: `mbox_seq`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_done` is 0 and no bus access is made. A request accepted while idle is followed in the next cycle by a read of offset 0x04.
- R2: If bit 0 of that first control read is 1, the request ends with `rsp_status` = 2, `rsp_rc` = 0 and `rsp_len` = 0, and the block makes no bus write at all.
- R3: The first write goes to offset 0x08. It carries the opcode in bits 15:0 and the input length in bits 36:16, with all other bits zero, so the length field is zero when there is no input payload.
- R4: Input bytes are packed little-endian into 64-bit words, byte i going to bits 8*(i mod 8)+7 : 8*(i mod 8) of word i/8. Word k is written to offset 0x20 + 8k. The unused bytes of a partial last word are zero. Exactly ceil(len/8) payload writes are made, and none when the length is zero.
- R5: After the payload writes, the block writes the value 1 to offset 0x04 (the doorbell) and then only reads offset 0x04 until it sees bit 0 clear.
- R6: Once the doorbell reads clear, offset 0x10 is read and its bits 47:32 are reported as `rsp_rc`.
- R7: A nonzero return code completes the request with `rsp_status` = 0 and `rsp_len` = 0. Offset 0x08 is not read back and no payload word is read or streamed out.
- R8: With a zero return code, offset 0x08 is read and bits 36:16 give the output length, limited to `PAYLOAD_BYTES`. Then ceil(length/8) window words are read and their bytes are streamed out in the same little-endian order. `rsp_len` equals the number of bytes streamed.
- R9: The doorbell is polled on `POLL_LIMIT` cycles and then checked once more. If that last check finds it clear, the command completes normally. Otherwise the request ends with `rsp_status` = 1 and `rsp_rc` = 0.
- R10: `rsp_done` is a single-cycle pulse, and `req_ready` is low from acceptance through the completion pulse.
- R11: While `out_valid` is high and `out_ready` low, `out_valid` stays high and `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client offers a command |
| req_ready | output | 1 | Sequencer idle, command accepted when valid is high |
| req_opcode | input | 16 | Command opcode |
| req_len | input | LEN_W | Input payload length in bytes |
| in_valid | input | 1 | Input payload byte available |
| in_ready | output | 1 | Sequencer takes an input byte |
| in_data | input | 8 | Input payload byte |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_addr | output | ADDR_W | Register byte offset |
| bus_wdata | output | 64 | Write data |
| bus_rdata | input | 64 | Read data, valid in the cycle of `bus_rd` |
| out_valid | output | 1 | Output payload byte available |
| out_ready | input | 1 | Client takes an output byte |
| out_data | output | 8 | Output payload byte |
| rsp_done | output | 1 | Completion pulse |
| rsp_status | output | 2 | 0 completed, 1 timed out, 2 busy at start |
| rsp_rc | output | 16 | Device return code |
| rsp_len | output | LEN_W | Output bytes delivered |

## Verification
The hardest case to reach is the narrow window around the deadline. The doorbell must still be set on the last regular poll and then be clear on the extra check, while one more cycle of delay must give a timeout. The bench's mailbox model clears the doorbell after a programmable number of cycles. Directed runs set that count to exactly the poll limit and to one past it, under a shortened deadline. A busy-at-start case is forced by holding the model's doorbell before the request arrives. Random runs mix lengths, return codes and stalls on both byte streams.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHK,
        ST_CMD,
        ST_FILL,
        ST_PWR,
        ST_BELL,
        ST_POLL,
        ST_LAST,
        ST_STAT,
        ST_LEN,
        ST_RD,
        ST_OUT,
        ST_DONE
    } seq_state_e;

    localparam logic [1:0] RES_OK   = 2'd0;
    localparam logic [1:0] RES_TMO  = 2'd1;
    localparam logic [1:0] RES_BUSY = 2'd2;

    localparam int OFS_CTRL = 'h04;
    localparam int OFS_CMD  = 'h08;
    localparam int OFS_STAT = 'h10;
    localparam int OFS_WIN  = 'h20;

endpackage

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
    parameter int LIMIT = 400000,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (run && !expired)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mbox_byte_lane.sv
module mbox_byte_lane (
    input  logic [63:0] word,
    input  logic [2:0]  sel,
    output logic [7:0]  lane
);
    logic [7:0] lanes [8];

    for (genvar g = 0; g < 8; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign lane = lanes[sel];
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
    import mbox_seq_pkg::*;
#(
    parameter int PAYLOAD_BYTES = 64,
    parameter int CLK_HZ        = 200_000_000,
    parameter int TIMEOUT_US    = 2000,
    parameter int ADDR_W        = 12,
    localparam int LEN_W        = $clog2(PAYLOAD_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_opcode,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [63:0]       bus_wdata,
    input  logic [63:0]       bus_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              rsp_done,
    output logic [1:0]        rsp_status,
    output logic [15:0]       rsp_rc,
    output logic [LEN_W-1:0]  rsp_len
);
    localparam int WORDS      = (PAYLOAD_BYTES + 7) / 8;
    localparam int WIDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int POLL_LIMIT = (CLK_HZ / 1_000_000) * TIMEOUT_US;

    typedef struct packed {
        seq_state_e        state;
        logic [15:0]       opcode;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
        logic [WIDX_W-1:0] widx;
        logic [63:0]       buff;
        logic [1:0]        res;
        logic [15:0]       rc;
        logic [LEN_W-1:0]  olen;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic        tmr_expired;
    logic [7:0]  lane_byte;
    logic [20:0] len_field;
    logic [LEN_W-1:0] cnt_inc;
    logic [ADDR_W-1:0] win_addr;

    mbox_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (r_q.state == ST_BELL),
        .run     (r_q.state == ST_POLL),
        .expired (tmr_expired)
    );

    mbox_byte_lane u_lane (
        .word (r_q.buff),
        .sel  (r_q.cnt[2:0]),
        .lane (lane_byte)
    );

    assign len_field = bus_rdata[36:16];
    assign cnt_inc   = r_q.cnt + 1'b1;
    assign win_addr  = ADDR_W'(OFS_WIN) + ADDR_W'({r_q.widx, 3'b000});

    assign req_ready  = (r_q.state == ST_IDLE);
    assign in_ready   = (r_q.state == ST_FILL);
    assign out_valid  = (r_q.state == ST_OUT);
    assign out_data   = lane_byte;
    assign rsp_done   = (r_q.state == ST_DONE);
    assign rsp_status = r_q.res;
    assign rsp_rc     = r_q.rc;
    assign rsp_len    = r_q.olen;

    always_comb begin
        r_d       = r_q;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.opcode = req_opcode;
                    r_d.len    = req_len;
                    r_d.cnt    = '0;
                    r_d.widx   = '0;
                    r_d.buff   = '0;
                    r_d.state  = ST_CHK;
                end
            end
            ST_CHK: begin
                bus_rd   = 1'b1;
                bus_addr = ADDR_W'(OFS_CTRL);
                if (bus_rdata[0]) begin
                    r_d.res   = RES_BUSY;
                    r_d.rc    = '0;
                    r_d.olen  = '0;
                    r_d.state = ST_DONE;
                end else begin
                    r_d.state = ST_CMD;
                end
            end
            ST_CMD: begin
                bus_wr    = 1'b1;
                bus_addr  = ADDR_W'(OFS_CMD);
                bus_wdata = {27'd0, 21'(r_q.len), r_q.opcode};
                r_d.state = (r_q.len != '0) ? ST_FILL : ST_BELL;
            end
            ST_FILL: begin
                if (in_valid) begin
                    r_d.buff[{r_q.cnt[2:0], 3'b000} +: 8] = in_data;
                    r_d.cnt = cnt_inc;
                    if (r_q.cnt[2:0] == 3'd7 || cnt_inc == r_q.len)
                        r_d.state = ST_PWR;
                end
            end
            ST_PWR: begin
                bus_wr    = 1'b1;
                bus_addr  = win_addr;
                bus_wdata = r_q.buff;
                r_d.buff  = '0;
                r_d.widx  = r_q.widx + 1'b1;
                r_d.state = (r_q.cnt == r_q.len) ? ST_BELL : ST_FILL;
            end
            ST_BELL: begin
                bus_wr    = 1'b1;
                bus_addr  = ADDR_W'(OFS_CTRL);
                bus_wdata = 64'd1;
                r_d.state = ST_POLL;
            end
            ST_POLL: begin
                bus_rd   = 1'b1;
                bus_addr = ADDR_W'(OFS_CTRL);
                if (!bus_rdata[0])
                    r_d.state = ST_STAT;
                else if (tmr_expired)
                    r_d.state = ST_LAST;
            end
            ST_LAST: begin
                bus_rd   = 1'b1;
                bus_addr = ADDR_W'(OFS_CTRL);
                if (!bus_rdata[0]) begin
                    r_d.state = ST_STAT;
                end else begin
                    r_d.res   = RES_TMO;
                    r_d.rc    = '0;
                    r_d.olen  = '0;
                    r_d.state = ST_DONE;
                end
            end
            ST_STAT: begin
                bus_rd   = 1'b1;
                bus_addr = ADDR_W'(OFS_STAT);
                r_d.rc   = bus_rdata[47:32];
                r_d.res  = RES_OK;
                r_d.olen = '0;
                r_d.state = (bus_rdata[47:32] != 16'd0) ? ST_DONE : ST_LEN;
            end
            ST_LEN: begin
                bus_rd   = 1'b1;
                bus_addr = ADDR_W'(OFS_CMD);
                r_d.olen = (len_field > 21'(PAYLOAD_BYTES)) ? LEN_W'(PAYLOAD_BYTES)
                                                             : LEN_W'(len_field);
                r_d.cnt  = '0;
                r_d.widx = '0;
                r_d.state = (r_d.olen == '0) ? ST_DONE : ST_RD;
            end
            ST_RD: begin
                bus_rd    = 1'b1;
                bus_addr  = win_addr;
                r_d.buff  = bus_rdata;
                r_d.state = ST_OUT;
            end
            ST_OUT: begin
                if (out_ready) begin
                    r_d.cnt = cnt_inc;
                    if (cnt_inc == r_q.olen) begin
                        r_d.state = ST_DONE;
                    end else if (r_q.cnt[2:0] == 3'd7) begin
                        r_d.widx  = r_q.widx + 1'b1;
                        r_d.state = ST_RD;
                    end
                end
            end
            ST_DONE: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/mbox_seq_chk.sv
module mbox_seq_chk #(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [63:0]       bus_wdata,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic              rsp_done,
    input logic [1:0]        rsp_status,
    input logic [15:0]       rsp_rc,
    input logic [LEN_W-1:0]  rsp_len
);
    // R1
    accept_reads_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_rd && !bus_wr && bus_addr == ADDR_W'(4)));

    // R5
    doorbell_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(4)) |-> (bus_wdata == 64'd1));

    // R5
    no_rd_wr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    // R7
    err_no_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_status == 2'd0 && rsp_rc != 16'd0) |-> (rsp_len == '0));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R10
    done_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready);

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    tmo_rc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_status == 2'd1) |-> (rsp_rc == 16'd0 && rsp_len == '0));
endmodule

bind mbox_seq mbox_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .rsp_done   (rsp_done),
    .rsp_status (rsp_status),
    .rsp_rc     (rsp_rc),
    .rsp_len    (rsp_len)
);

// File: tb/mbox_seq_bench.sv
`timescale 1ns/100ps
module mbox_seq_bench;
    localparam int PB     = 64;
    localparam int LEN_W  = $clog2(PB + 1);
    localparam int ADDR_W = 12;
    localparam int LIMIT  = 40;
    localparam int WORDS  = (PB + 7) / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [15:0] req_opcode = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [7:0] in_data = '0;
    logic bus_wr, bus_rd;
    logic [ADDR_W-1:0] bus_addr;
    logic [63:0] bus_wdata, bus_rdata;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [7:0] out_data;
    logic rsp_done;
    logic [1:0] rsp_status;
    logic [15:0] rsp_rc;
    logic [LEN_W-1:0] rsp_len;

    always #2.5 clk = ~clk;

    mbox_seq #(.PAYLOAD_BYTES(PB), .CLK_HZ(1_000_000), .TIMEOUT_US(LIMIT),
               .ADDR_W(ADDR_W)) u_mbox_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_len(req_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .rsp_done(rsp_done), .rsp_status(rsp_status), .rsp_rc(rsp_rc),
        .rsp_len(rsp_len)
    );

    // ---------------- mailbox device model ----------------
    int          dev_delay = 0;
    logic [15:0] dev_rc = '0;
    int          dev_olen = 0;
    logic [7:0]  dev_out [PB];
    bit          force_busy = 1'b0;

    logic        m_bell = 1'b0;
    int          m_cnt = 0;
    logic [63:0] m_cmd = '0;
    logic [63:0] m_stat = '0;
    logic [63:0] m_pay [WORDS];

    logic [ADDR_W-1:0] wl_addr [1024];
    logic [63:0]       wl_data [1024];
    int wn = 0, rd_cmd_n = 0, rd_pay_n = 0, rd_stat_n = 0, rd_n = 0;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(4))       bus_rdata = {63'd0, m_bell};
        else if (bus_addr == ADDR_W'(8))  bus_rdata = m_cmd;
        else if (bus_addr == ADDR_W'(16)) bus_rdata = m_stat;
        else if (bus_addr >= ADDR_W'(32) && bus_addr < ADDR_W'(32 + 8*WORDS))
            bus_rdata = m_pay[(int'(bus_addr) - 32) / 8];
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_rd) begin
                rd_n <= rd_n + 1;
                if (bus_addr == ADDR_W'(8))  rd_cmd_n  <= rd_cmd_n + 1;
                if (bus_addr == ADDR_W'(16)) rd_stat_n <= rd_stat_n + 1;
                if (bus_addr >= ADDR_W'(32)) rd_pay_n  <= rd_pay_n + 1;
            end
            if (bus_wr) begin
                wl_addr[wn % 1024] <= bus_addr;
                wl_data[wn % 1024] <= bus_wdata;
                wn <= wn + 1;
                if (bus_addr == ADDR_W'(8)) m_cmd <= bus_wdata;
                if (bus_addr >= ADDR_W'(32) && bus_addr < ADDR_W'(32 + 8*WORDS))
                    m_pay[(int'(bus_addr) - 32) / 8] <= bus_wdata;
            end
            if (force_busy) begin
                m_bell <= 1'b1;
            end else if (bus_wr && bus_addr == ADDR_W'(4) && bus_wdata[0]) begin
                m_bell <= 1'b1;
                m_cnt  <= dev_delay;
            end else if (m_bell) begin
                if (m_cnt == 0) begin
                    m_bell <= 1'b0;
                    m_stat <= {16'd0, dev_rc, 32'd0};
                    m_cmd[36:16] <= 21'(dev_olen);
                    for (int k = 0; k < WORDS; k++)
                        for (int b = 0; b < 8; b++)
                            m_pay[k][8*b +: 8] <= dev_out[8*k + b];
                end else begin
                    m_cnt <= m_cnt - 1;
                end
            end
        end
    end

    // ---------------- checking ----------------
    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_word(input logic [7:0] b [PB], input int len, input int k);
        logic [63:0] w = '0;
        for (int i = 0; i < 8; i++)
            if (8*k + i < len) w[8*i +: 8] = b[8*k + i];
        return w;
    endfunction

    logic [7:0] in_b [PB];
    logic [7:0] got  [PB + 8];

    task automatic run_cmd(input logic [15:0] op, input int len, input int dly,
                           input logic [15:0] rc, input int olen, input bit busy,
                           input int exp_stat);
        int wn0, rcmd0, rpay0, rstat0, idx, gn, exp_len;
        bit done, taken;
        logic [1:0] st;
        logic [15:0] rrc;
        int rlen;
        for (int i = 0; i < PB; i++) begin
            in_b[i]    = 8'($urandom);
            dev_out[i] = 8'($urandom);
        end
        dev_delay = dly; dev_rc = rc; dev_olen = olen;
        if (busy) begin
            force_busy = 1'b1;
            @(negedge clk);
        end
        @(negedge clk);
        wn0 = wn; rcmd0 = rd_cmd_n; rpay0 = rd_pay_n; rstat0 = rd_stat_n;
        idx = 0; gn = 0; done = 0; taken = 0;
        st = '0; rrc = '0; rlen = 0;
        req_valid = 1'b1; req_opcode = op; req_len = LEN_W'(len);
        while (!done) begin
            in_valid  = (idx < len) && ($urandom % 4 != 0);
            in_data   = in_b[(idx < PB) ? idx : 0];
            out_ready = ($urandom % 3 != 0);
            #1;
            if (req_valid && req_ready) taken = 1;
            if (in_valid && in_ready) idx++;
            if (out_valid && out_ready && gn < PB + 8) begin got[gn] = out_data; gn++; end
            if (rsp_done) begin done = 1; st = rsp_status; rrc = rsp_rc; rlen = int'(rsp_len); end
            @(negedge clk);
            if (taken) req_valid = 1'b0;
        end
        in_valid = 1'b0; out_ready = 1'b0;
        force_busy = 1'b0;
        while (m_bell) @(negedge clk);

        // R2 R9 R6 result class and code
        chk(st == 2'(exp_stat), "R9/R2 status", st, exp_stat);
        if (exp_stat == 0) chk(rrc == rc, "R6 return code", rrc, rc);
        else               chk(rrc == 0, "R9/R2 code zero", rrc, 0);
        exp_len = (exp_stat == 0 && rc == 0) ? ((olen > PB) ? PB : olen) : 0;
        chk(rlen == exp_len, "R8/R7 rsp_len", rlen, exp_len);
        chk(gn == exp_len, "R8 streamed count", gn, exp_len);
        for (int i = 0; i < exp_len && i < gn; i++)
            chk(got[i] == dev_out[i], "R8/R11 out byte", got[i], dev_out[i]);
        if (exp_stat == 2) begin
            chk(wn == wn0, "R2 no writes", wn - wn0, 0);
        end else begin
            int nw = (len + 7) / 8;
            chk(wn - wn0 == nw + 2, "R4/R5 write count", wn - wn0, nw + 2);
            chk(wl_addr[wn0 % 1024] == ADDR_W'(8) &&
                wl_data[wn0 % 1024] == {27'd0, 21'(len), op},
                "R3 command word", wl_data[wn0 % 1024], {27'd0, 21'(len), op});
            for (int k = 0; k < nw; k++) begin
                int e = (wn0 + 1 + k) % 1024;
                chk(wl_addr[e] == ADDR_W'(32 + 8*k) && wl_data[e] == exp_word(in_b, len, k),
                    "R4 payload word", wl_data[e], exp_word(in_b, len, k));
            end
            chk(wl_addr[(wn0 + 1 + nw) % 1024] == ADDR_W'(4) &&
                wl_data[(wn0 + 1 + nw) % 1024] == 64'd1,
                "R5 doorbell write", wl_addr[(wn0 + 1 + nw) % 1024], 4);
        end
        if (exp_stat == 0) begin
            chk(rd_stat_n - rstat0 == 1, "R6 status read", rd_stat_n - rstat0, 1);
            if (rc != 0) begin
                chk(rd_cmd_n - rcmd0 == 0, "R7 no length readback", rd_cmd_n - rcmd0, 0);
                chk(rd_pay_n - rpay0 == 0, "R7 no payload read", rd_pay_n - rpay0, 0);
            end else begin
                chk(rd_pay_n - rpay0 == (exp_len + 7) / 8, "R8 payload reads",
                    rd_pay_n - rpay0, (exp_len + 7) / 8);
            end
        end else begin
            chk(rd_stat_n - rstat0 == 0, "R9/R2 no status read", rd_stat_n - rstat0, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        chk(rsp_done == 1'b0, "R1 rsp_done", rsp_done, 0);
        chk(!bus_wr && !bus_rd && rd_n == 0 && wn == 0, "R1 bus idle", rd_n + wn, 0);

        // directed corners
        run_cmd(16'h4000, 0, 3, 16'h0, 0, 0, 0);            // R3 zero length, no output
        run_cmd(16'h1234, PB, 5, 16'h0, PB, 0, 0);          // R4 R8 full window
        run_cmd(16'h00a5, 9, 2, 16'h0, 13, 0, 0);           // R4 partial last word
        run_cmd(16'h0101, 4, 1, 16'h0, PB + 5, 0, 0);       // R8 length limited
        run_cmd(16'h0202, 8, 2, 16'h0017, 20, 0, 0);        // R7 error code
        run_cmd(16'h0303, 5, 2, 16'h0, 4, 1, 2);            // R2 busy at start
        run_cmd(16'h0404, 3, LIMIT, 16'h0, 6, 0, 0);        // R9 clear on final check
        run_cmd(16'h0505, 3, LIMIT + 1, 16'h0, 6, 0, 1);    // R9 timeout
        run_cmd(16'h0606, 0, 3 * LIMIT, 16'h0, 6, 0, 1);    // R9 long stall
        run_cmd(16'h0707, 1, 0, 16'h0, 1, 0, 0);            // R5 immediate clear

        for (int n = 0; n < 25; n++) begin
            int l  = int'($urandom % (PB + 1));
            int ol = int'($urandom % (PB + 1));
            logic [15:0] c = ($urandom % 4 == 0) ? (16'($urandom) | 16'h1) : 16'h0;
            run_cmd(16'($urandom), l, int'($urandom % 20), c, ol, 0, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule